// File: doc/BRIEF.md
# Rotary Channel Selector Controller

This block keeps the operating channel of a 40-channel citizen-band radio. It reads the two contact lines of a rotary switch, one closing per clockwise detent and one per anticlockwise detent, debounces them, and steps a channel number up or down with wrap-around. On every change it registers two outputs in the same cycle. One is the channel shown as two seven-segment digits. The other is the 9-bit divide ratio for the synthesizer's programmable divider.

The ratio comes from a computed table that follows the standard 40-channel plan. Channels are spaced 10 kHz apart, with single-step gaps after some channels and one channel placed out of order.

The block also takes the loop-lock indication and a push-to-talk request. It gates the transmit enable and the receive-audio enable so that neither is active while the loop is unlocked.

All outputs are plain registered levels. No data stream crosses the block edge, so there is no valid/ready pairing and no back-pressure: the divider and the display simply follow the registers.

Top module: `chan_sel_ctrl`

## Requirements
- R1: The internal channel number is always in 1..40, and no other value is ever reached.
- R2: A counted clockwise step raises the channel by one. From channel 40 it goes to channel 1.
- R3: A counted anticlockwise step lowers the channel by one. From channel 1 it goes to channel 40.
- R4: After reset the block selects channel 9. The display shows "09" and the divide ratio is 236.
- R5: The divide ratio N is computed per channel as follows. For channels 1..22, N = 225 + ch + min(ch/4, 5), with integer division. Channel 23 gives N = 255. Channels 24..25 give N = 229 + ch. Channels 26..40 give N = 230 + ch. Channel 1 is 226 and channel 40 is 270, so N always stays in 226..270.
- R6: Each display output is 7 bits, active high: bit 0 is segment a and bit 6 is segment g. The digit codes are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F and 9=0x6F. Channels 1..9 show a leading zero on the tens digit.
- R7: The divide-ratio register and the display registers change on the same clock edge, and never one without the other.
- R8: A contact line is synchronized by two flops. Its debounced level changes only after the synchronized level has differed from it for DEB_CYCLES consecutive clocks. A closure shorter than that is ignored. Only the closing (rising) transition of the debounced level counts as a step; release does not.
- R9: If clockwise and anticlockwise steps are counted in the same cycle, the channel does not change.
- R10: rx_aud_en_o equals the synchronized lock input. tx_en_o equals the synchronized lock AND the synchronized push-to-talk input. Each takes effect on the third rising edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cw_raw_i | input | 1 | Raw clockwise contact, high while closed |
| ccw_raw_i | input | 1 | Raw anticlockwise contact, high while closed |
| ptt_i | input | 1 | Push-to-talk request, asynchronous |
| lock_i | input | 1 | Loop lock indication, asynchronous |
| seg_tens_o | output | 7 | Tens digit segments {g..a} |
| seg_ones_o | output | 7 | Ones digit segments {g..a} |
| div_ratio_o | output | 9 | Programmable divider ratio N |
| tx_en_o | output | 1 | Transmit enable, gated by lock |
| rx_aud_en_o | output | 1 | Receive audio enable, gated by lock |

## Verification
A corrupted channel register shows up on the ports one clock after it goes wrong: both the divide ratio and the display move to an unexpected pair. The scoreboard flags this as a mismatch or as an unrequested change. A table fault near the gaps or at channel 23 only shows when that channel is visited, so the stimulus walks the full ring in both directions. A debounce or edge-detect fault appears as an extra or missing step at the next closure or release, and a gating fault appears within three clocks of a lock or push-to-talk transition.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int CH_W    = 6;
  localparam int DIV_W   = 9;
  localparam int SEG_W   = 7;
  localparam int CH_LO   = 1;
  localparam int CH_HI   = 40;
  localparam int CH_RST  = 9;

  typedef logic [CH_W-1:0]  chan_t;
  typedef logic [DIV_W-1:0] div_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Divider ratio for a channel: 10 kHz raster with plan gaps.
  function automatic div_t chan_to_div(input chan_t ch);
    int c;
    int n;
    c = int'(ch);
    if (c <= 22)      n = 225 + c + c / 4;
    else if (c == 23) n = 255;
    else if (c <= 25) n = 229 + c;
    else              n = 230 + c;
    return DIV_W'(n);
  endfunction

  // Active-high segments, bit0 = a .. bit6 = g.
  function automatic seg_t digit_to_seg(input logic [3:0] d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/chsel_debounce.sv
module chsel_debounce #(
  parameter int DEB_CYCLES = 800_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic press_o
);
  localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;
  logic             stable_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      stable_q   <= 1'b0;
      stable_d_q <= 1'b0;
    end else begin
      stable_d_q <= stable_q;
      if (level_i == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q    <= '0;
        stable_q <= level_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = stable_q & ~stable_d_q;
endmodule

// File: rtl/chsel_chan_reg.sv
module chsel_chan_reg
  import chsel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  up_i,
  input  logic  dn_i,
  output chan_t chan_o
);
  chan_t chan_q;
  chan_t chan_d;

  always_comb begin
    chan_d = chan_q;
    if (up_i && !dn_i)
      chan_d = (chan_q == CH_W'(CH_HI)) ? CH_W'(CH_LO) : chan_q + 1'b1;
    else if (dn_i && !up_i)
      chan_d = (chan_q == CH_W'(CH_LO)) ? CH_W'(CH_HI) : chan_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_q <= CH_W'(CH_RST);
    else         chan_q <= chan_d;
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/chan_sel_ctrl.sv
module chan_sel_ctrl
  import chsel_pkg::*;
#(
  parameter int DEB_CYCLES = 800_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cw_raw_i,
  input  logic             ccw_raw_i,
  input  logic             ptt_i,
  input  logic             lock_i,
  output logic [SEG_W-1:0] seg_tens_o,
  output logic [SEG_W-1:0] seg_ones_o,
  output logic [DIV_W-1:0] div_ratio_o,
  output logic             tx_en_o,
  output logic             rx_aud_en_o
);
  localparam int N_STEP = 2;
  localparam chan_t RST_CH = CH_W'(CH_RST);

  logic [3:0]        sync_s;
  logic [N_STEP-1:0] raw_step;
  logic [N_STEP-1:0] press;
  logic              step_up;
  logic              step_dn;
  logic              ptt_s;
  logic              lock_s;
  chan_t             chan_q;

  chsel_sync #(.WIDTH(4)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lock_i, ptt_i, ccw_raw_i, cw_raw_i}),
    .q_o    (sync_s)
  );

  assign raw_step = sync_s[1:0];
  assign ptt_s    = sync_s[2];
  assign lock_s   = sync_s[3];

  for (genvar i = 0; i < N_STEP; i++) begin : g_deb
    chsel_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (raw_step[i]),
      .press_o (press[i])
    );
  end

  assign step_up = press[0];
  assign step_dn = press[1];

  chsel_chan_reg u_chan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .up_i   (step_up),
    .dn_i   (step_dn),
    .chan_o (chan_q)
  );

  // Display and divider registers load from the same channel value.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_ratio_o <= chan_to_div(RST_CH);
      seg_tens_o  <= digit_to_seg(4'(RST_CH / 6'd10));
      seg_ones_o  <= digit_to_seg(4'(RST_CH % 6'd10));
      tx_en_o     <= 1'b0;
      rx_aud_en_o <= 1'b0;
    end else begin
      div_ratio_o <= chan_to_div(chan_q);
      seg_tens_o  <= digit_to_seg(4'(chan_q / 6'd10));
      seg_ones_o  <= digit_to_seg(4'(chan_q % 6'd10));
      tx_en_o     <= lock_s & ptt_s;
      rx_aud_en_o <= lock_s;
    end
  end
endmodule

// File: rtl/chsel_chk.sv
module chsel_chk
  import chsel_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input chan_t            chan_q,
  input logic             step_up,
  input logic             step_dn,
  input logic             lock_s,
  input logic             ptt_s,
  input logic [DIV_W-1:0] div_ratio_o,
  input logic [SEG_W-1:0] seg_ones_o,
  input logic             tx_en_o,
  input logic             rx_aud_en_o
);
  p_chan_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_q >= CH_W'(CH_LO) && chan_q <= CH_W'(CH_HI));

  p_cw_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_up && !step_dn) |=>
      chan_q == (($past(chan_q) == CH_W'(CH_HI)) ? CH_W'(CH_LO) : $past(chan_q) + 1'b1));

  p_ccw_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_dn && !step_up) |=>
      chan_q == (($past(chan_q) == CH_W'(CH_LO)) ? CH_W'(CH_HI) : $past(chan_q) - 1'b1));

  p_div_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_ratio_o >= 9'd226 && div_ratio_o <= 9'd270);

  p_div_with_seg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_ratio_o) |-> !$stable(seg_ones_o));

  p_seg_with_div_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_ones_o) |-> !$stable(div_ratio_o));

  p_both_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_up && step_dn) |=> $stable(chan_q));

  p_unlock_mutes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_s |=> (!tx_en_o && !rx_aud_en_o));

  p_lock_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_s && ptt_s) |=> (tx_en_o && rx_aud_en_o));
endmodule

bind chan_sel_ctrl chsel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_q      (chan_q),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .lock_s      (lock_s),
  .ptt_s       (ptt_s),
  .div_ratio_o (div_ratio_o),
  .seg_ones_o  (seg_ones_o),
  .tx_en_o     (tx_en_o),
  .rx_aud_en_o (rx_aud_en_o)
);

// File: tb/chan_sel_ctrl_tb_top.sv
`timescale 1ns/1ps
module chan_sel_ctrl_tb_top;
  localparam int DEB = 8;
  localparam int HOLD = DEB + 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cw_raw_i = 1'b0;
  logic       ccw_raw_i = 1'b0;
  logic       ptt_i = 1'b0;
  logic       lock_i = 1'b1;
  logic [6:0] seg_tens_o;
  logic [6:0] seg_ones_o;
  logic [8:0] div_ratio_o;
  logic       tx_en_o;
  logic       rx_aud_en_o;

  int checks = 0;
  int failures = 0;
  int model_ch = 9;
  int exp_q[$];
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [22:0] prev_obs;

  always #2.5 clk_i = ~clk_i;

  chan_sel_ctrl #(.DEB_CYCLES(DEB)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cw_raw_i    (cw_raw_i),
    .ccw_raw_i   (ccw_raw_i),
    .ptt_i       (ptt_i),
    .lock_i      (lock_i),
    .seg_tens_o  (seg_tens_o),
    .seg_ones_o  (seg_ones_o),
    .div_ratio_o (div_ratio_o),
    .tx_en_o     (tx_en_o),
    .rx_aud_en_o (rx_aud_en_o)
  );

  function automatic int ref_n(input int ch);
    case (ch)
      1: return 226;  2: return 227;  3: return 228;  4: return 230;
      5: return 231;  6: return 232;  7: return 233;  8: return 235;
      9: return 236;  10: return 237; 11: return 238; 12: return 240;
      13: return 241; 14: return 242; 15: return 243; 16: return 245;
      17: return 246; 18: return 247; 19: return 248; 20: return 250;
      21: return 251; 22: return 252; 23: return 255; 24: return 253;
      25: return 254; 26: return 256; 27: return 257; 28: return 258;
      29: return 259; 30: return 260; 31: return 261; 32: return 262;
      33: return 263; 34: return 264; 35: return 265; 36: return 266;
      37: return 267; 38: return 268; 39: return 269; 40: return 270;
      default: return -1;
    endcase
  endfunction

  function automatic logic [6:0] ref_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_ch(input string req, input int ch);
    check(int'(div_ratio_o) == ref_n(ch), req, "divide ratio", int'(div_ratio_o), ref_n(ch));
    check(seg_tens_o == ref_seg(ch / 10), req, "tens segments", int'(seg_tens_o), int'(ref_seg(ch / 10)));
    check(seg_ones_o == ref_seg(ch % 10), req, "ones segments", int'(seg_ones_o), int'(ref_seg(ch % 10)));
  endtask

  // Scoreboard monitor: every output change must match the next queued channel.
  always @(negedge clk_i) begin
    if (rst_ni && mon_en) begin
      if ({div_ratio_o, seg_tens_o, seg_ones_o} !== prev_obs) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unrequested output change, div", int'(div_ratio_o), int'(prev_obs[22:14]));
        end else begin
          int ch;
          ch = exp_q.pop_front();
          check_ch((ch == 1 || ch == 40) ? "R2/R3 wrap" : "R5/R6", ch);
        end
        prev_obs = {div_ratio_o, seg_tens_o, seg_ones_o};
      end
    end
  end

  task automatic press(input bit cw, input bit ccw, input int hold);
    @(posedge clk_i); #1;
    cw_raw_i = cw; ccw_raw_i = ccw;
    repeat (hold) @(posedge clk_i);
    #1; cw_raw_i = 1'b0; ccw_raw_i = 1'b0;
    repeat (HOLD) @(posedge clk_i);
  endtask

  task automatic step_cw();
    model_ch = (model_ch == 40) ? 1 : model_ch + 1;
    exp_q.push_back(model_ch);
    press(1'b1, 1'b0, HOLD);
  endtask

  task automatic step_ccw();
    model_ch = (model_ch == 1) ? 40 : model_ch - 1;
    exp_q.push_back(model_ch);
    press(1'b0, 1'b1, HOLD);
  endtask

  initial begin : watchdog
    repeat (100_000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    // R4: reset channel 9
    check_ch("R4", 9);
    check(tx_en_o == 1'b0, "R4", "tx_en after reset", int'(tx_en_o), 0);
    prev_obs = {div_ratio_o, seg_tens_o, seg_ones_o};
    mon_en = 1'b1;

    // R2 and R5: walk up through the gaps and channel 23 to 40, then wrap
    for (int i = 0; i < 32; i++) step_cw();
    // R3: wrap down from 1 to 40, then two more
    for (int i = 0; i < 3; i++) step_ccw();
    @(negedge clk_i);
    check(exp_q.size() == 0, "R2/R3", "pending steps", exp_q.size(), 0);
    check(model_ch == 38, "R3", "model channel", model_ch, 38);

    // R8: short closure ignored
    press(1'b1, 1'b0, DEB / 2);
    press(1'b0, 1'b1, DEB / 2);
    @(negedge clk_i);
    check_ch("R8 short pulse", 38);

    // R9: both directions at once
    press(1'b1, 1'b1, HOLD);
    @(negedge clk_i);
    check_ch("R9 simultaneous", 38);

    // R1: walk down the whole ring once more
    for (int i = 0; i < 38; i++) step_ccw();
    @(negedge clk_i);
    check(exp_q.size() == 0, "R1", "pending steps", exp_q.size(), 0);
    check_ch("R1", model_ch);

    // R10: lock gating with three-edge latency
    @(posedge clk_i); #1 ptt_i = 1'b1;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    check(tx_en_o == 1'b1, "R10", "tx_en locked+ptt", int'(tx_en_o), 1);
    check(rx_aud_en_o == 1'b1, "R10", "rx_aud locked", int'(rx_aud_en_o), 1);
    @(posedge clk_i); #1 lock_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check(tx_en_o == 1'b1, "R10", "tx_en before latency", int'(tx_en_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    check(tx_en_o == 1'b0, "R10", "tx_en unlocked", int'(tx_en_o), 0);
    check(rx_aud_en_o == 1'b0, "R10", "rx_aud unlocked", int'(rx_aud_en_o), 0);
    @(posedge clk_i); #1 lock_i = 1'b1; ptt_i = 1'b0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    check(tx_en_o == 1'b0, "R10", "tx_en no ptt", int'(tx_en_o), 0);
    check(rx_aud_en_o == 1'b1, "R10", "rx_aud relocked", int'(rx_aud_en_o), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule